// File: doc/BRIEF.md
# Region Lock Unit for Atomic Read-Modify-Write

This unit is shared by several processor cores. Its job is to serialise their atomic read-modify-write sequences on a per-region basis. Before it starts an atomic sequence, a core raises its request line and drives the target byte address. The unit reduces that address to a region tag by dropping the offset inside a 64-byte line. If no other core holds that region and a lock entry is free, the unit records the region and the owning core in its lock table and raises the core's grant.

If the region is already held, or every entry is in use, the unit raises the core's stall instead. The core stays queued until the unit can grant it. A holder pulses its done line to release its region. Waiting cores are then served in the order in which they arrived. When several cores arrive in the same cycle, the lowest core index goes first.

Cores that work on different regions never hold each other up. Several such cores can be granted in the same cycle, as long as the table has room for them. A done pulse from a core that holds nothing changes no lock. It does set a sticky error flag.

Top module: `region_lock_unit`

## Requirements
- R1: After reset every bit of grant_o, stall_o and err_o is 0 and the lock table is empty, so the first request is granted at once.
- R2: The region tag is addr[ADDR_W-1:6]. Two addresses in the same 64-byte line conflict. Addresses in adjacent lines do not conflict.
- R3: A request on a free region, sampled at a clock edge while the core is idle, raises that core's grant_o after the same edge with stall_o low. The grant then stays high until the core's done_i is sampled.
- R4: A request on a region that another core holds raises the requester's stall_o after the sampling edge. stall_o stays high until the grant arrives. No two cores ever hold the same region at once.
- R5: When done_i is sampled from a holder, its grant_o falls after that edge. The next eligible waiter's grant_o rises one edge later.
- R6: Waiters on one region are granted in arrival order. Among cores that arrived in the same cycle, the lower core index is granted first. A later arrival never overtakes an earlier waiter.
- R7: Requests for distinct regions made in the same cycle are all granted after that edge, with no stall, provided enough entries are free.
- R8: The table holds NUM_ENTRIES locks (2 by default). A request that finds no free entry stalls. It is granted when an entry frees up, in arrival and priority order among the eligible waiters.
- R9: A done_i pulse from a core that is not holding a grant leaves every grant_o and stall_o unchanged. It sets err_o, which stays 1 until reset.
- R10: A core that is holding a grant ignores req_i; its grant and the stall of the other cores are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CORES | Lock request, one bit per core |
| addr_i | input | NUM_CORES*ADDR_W | Target byte address per core; core c uses bits [c*ADDR_W +: ADDR_W] |
| done_i | input | NUM_CORES | Release pulse per core |
| grant_o | output | NUM_CORES | Core holds its region |
| stall_o | output | NUM_CORES | Core is queued and must wait |
| err_o | output | 1 | Sticky flag: a release came from a core that held nothing |

## Verification
The first stimulus is a single request on an empty table, which shows the basic grant latency. Next come address pairs at the edges of a line, such as offset 0 against 63 and 63 against 64, swept over every pair of cores in the same cycle. These separate a line conflict from an independent grant, and they confirm the fixed index priority for every pairing. Staggered arrivals from a high-index core followed by a low-index core show that arrival order beats index. A fully occupied table shows that stalls caused by capacity are kept apart from stalls caused by a region conflict. Finally, stray done pulses from idle and from stalled cores are checked for having no side effects.

// File: rtl/rl_pkg.sv
package rl_pkg;

    // Per-core phase of the lock protocol
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HOLD = 2'd2
    } core_phase_e;

    // Default granularity of a lockable region: 64-byte line
    localparam int unsigned LINE_BITS_DEF = 6;

endpackage

// File: rtl/rl_lock_table.sv
module rl_lock_table #(
    parameter int unsigned NUM_CORES   = 4,
    parameter int unsigned NUM_ENTRIES = 2,
    parameter int unsigned TAG_W       = 10,
    localparam int unsigned OWN_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int unsigned CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CORES-1:0][TAG_W-1:0]   tag_i,
    input  logic [NUM_CORES-1:0]              alloc_i,
    input  logic [NUM_CORES-1:0]              rel_i,
    output logic [NUM_CORES-1:0]              hit_o,
    output logic [CNT_W-1:0]                  free_cnt_o
);

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [OWN_W-1:0] owner;
    } entry_t;

    entry_t [NUM_ENTRIES-1:0] tbl_d, tbl_q;

    // Next table: release owned entries, then place each allocation
    always_comb begin
        logic [NUM_ENTRIES-1:0] taken;
        logic                   placed;
        tbl_d = tbl_q;
        taken = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (tbl_q[e].valid && rel_i[tbl_q[e].owner]) begin
                tbl_d[e].valid = 1'b0;
            end
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            placed = 1'b0;
            if (alloc_i[c]) begin
                for (int e = 0; e < NUM_ENTRIES; e++) begin
                    if (!placed && !tbl_q[e].valid && !taken[e]) begin
                        tbl_d[e].valid = 1'b1;
                        tbl_d[e].tag   = tag_i[c];
                        tbl_d[e].owner = OWN_W'(c);
                        taken[e]       = 1'b1;
                        placed         = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Lookup of each core's tag, and count of free entries
    always_comb begin
        int n;
        n = 0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (!tbl_q[e].valid) n = n + 1;
        end
        free_cnt_o = CNT_W'(n);
        for (int c = 0; c < NUM_CORES; c++) begin
            hit_o[c] = 1'b0;
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (tbl_q[e].valid && tbl_q[e].tag == tag_i[c]) hit_o[c] = 1'b1;
            end
        end
    end

    // R8: never more allocations than free entries
    assert_alloc_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_i) <= free_cnt_o);

    // R4: one region is never held by two entries
    for (genvar a = 0; a < NUM_ENTRIES; a++) begin : g_ex_a
        for (genvar b = a + 1; b < NUM_ENTRIES; b++) begin : g_ex_b
            assert_region_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !(tbl_q[a].valid && tbl_q[b].valid && tbl_q[a].tag == tbl_q[b].tag));
        end
    end

endmodule

// File: rtl/rl_arrival_order.sv
module rl_arrival_order #(
    parameter int unsigned NUM_CORES = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_CORES-1:0]                 wait_i,
    input  logic [NUM_CORES-1:0]                 join_i,
    output logic [NUM_CORES-1:0][NUM_CORES-1:0]  ahead_o
);

    // older_q[i][j]: core i started waiting strictly before core j
    logic [NUM_CORES-1:0][NUM_CORES-1:0] older_d, older_q;

    always_comb begin
        older_d = older_q;
        for (int j = 0; j < NUM_CORES; j++) begin
            if (join_i[j]) begin
                for (int i = 0; i < NUM_CORES; i++) begin
                    older_d[i][j] = wait_i[i];
                    older_d[j][i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            older_q <= older_d;
        end
    end

    // ahead_o[i][j]: core j goes before core i
    always_comb begin
        for (int i = 0; i < NUM_CORES; i++) begin
            for (int j = 0; j < NUM_CORES; j++) begin
                if (i == j) begin
                    ahead_o[i][j] = 1'b0;
                end else if (wait_i[j] != wait_i[i]) begin
                    ahead_o[i][j] = wait_i[j];
                end else if (wait_i[j]) begin
                    ahead_o[i][j] = older_q[j][i] || (!older_q[i][j] && (j < i));
                end else begin
                    ahead_o[i][j] = (j < i);
                end
            end
        end
    end

    // R6: arrival order between two waiters is never contradictory
    for (genvar a = 0; a < NUM_CORES; a++) begin : g_ord_a
        for (genvar b = a + 1; b < NUM_CORES; b++) begin : g_ord_b
            assert_order_antisym_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wait_i[a] && wait_i[b]) |-> !(older_q[a][b] && older_q[b][a]));
        end
    end

endmodule

// File: rtl/region_lock_unit.sv
module region_lock_unit
    import rl_pkg::*;
#(
    parameter int unsigned NUM_CORES   = 4,
    parameter int unsigned NUM_ENTRIES = 2,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned LINE_BITS   = LINE_BITS_DEF,
    localparam int unsigned TAG_W      = ADDR_W - LINE_BITS,
    localparam int unsigned CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          req_i,
    input  logic [NUM_CORES*ADDR_W-1:0]   addr_i,
    input  logic [NUM_CORES-1:0]          done_i,
    output logic [NUM_CORES-1:0]          grant_o,
    output logic [NUM_CORES-1:0]          stall_o,
    output logic                          err_o
);

    typedef struct packed {
        core_phase_e [NUM_CORES-1:0]            phase;
        logic        [NUM_CORES-1:0][TAG_W-1:0] tag;
        logic                                   err;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [NUM_CORES-1:0]                waiting, holding, cand;
    logic [NUM_CORES-1:0][TAG_W-1:0]     tag_now;
    logic [NUM_CORES-1:0]                hit, region_ok, win, join_q, rel;
    logic [NUM_CORES-1:0][NUM_CORES-1:0] ahead;
    logic [CNT_W-1:0]                    free_cnt;

    // Candidate set and the region each candidate targets
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            waiting[c] = (st_q.phase[c] == PH_WAIT);
            holding[c] = (st_q.phase[c] == PH_HOLD);
            cand[c]    = waiting[c] || (st_q.phase[c] == PH_IDLE && req_i[c]);
            tag_now[c] = waiting[c] ? st_q.tag[c]
                                    : addr_i[c*ADDR_W + LINE_BITS +: TAG_W];
        end
    end

    rl_lock_table #(
        .NUM_CORES   (NUM_CORES),
        .NUM_ENTRIES (NUM_ENTRIES),
        .TAG_W       (TAG_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .tag_i      (tag_now),
        .alloc_i    (win),
        .rel_i      (rel),
        .hit_o      (hit),
        .free_cnt_o (free_cnt)
    );

    rl_arrival_order #(
        .NUM_CORES (NUM_CORES)
    ) u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_i  (waiting),
        .join_i  (join_q),
        .ahead_o (ahead)
    );

    // Arbitration and next state
    always_comb begin
        logic blocked;
        int   rank;
        st_d = st_q;
        for (int c = 0; c < NUM_CORES; c++) begin
            blocked = hit[c];
            for (int j = 0; j < NUM_CORES; j++) begin
                if (j != c && cand[j] && ahead[c][j] && tag_now[j] == tag_now[c]) begin
                    blocked = 1'b1;
                end
            end
            region_ok[c] = cand[c] && !blocked;
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            rank = 0;
            for (int j = 0; j < NUM_CORES; j++) begin
                if (region_ok[j] && ahead[c][j]) rank = rank + 1;
            end
            win[c] = region_ok[c] && (rank < int'(free_cnt));
        end
        rel    = done_i & holding;
        join_q = cand & ~win & ~waiting;
        for (int c = 0; c < NUM_CORES; c++) begin
            unique case (st_q.phase[c])
                PH_IDLE: begin
                    if (req_i[c]) begin
                        st_d.tag[c]   = tag_now[c];
                        st_d.phase[c] = win[c] ? PH_HOLD : PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (win[c]) st_d.phase[c] = PH_HOLD;
                end
                PH_HOLD: begin
                    if (done_i[c]) st_d.phase[c] = PH_IDLE;
                end
                default: st_d.phase[c] = PH_IDLE;
            endcase
        end
        st_d.err = st_q.err || |(done_i & ~holding);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = holding;
    assign stall_o = waiting;
    assign err_o   = st_q.err;

    // R9: error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
        // R3: grant held until done
        assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[c] && !done_i[c]) |=> grant_o[c]);
        // R5: done releases the grant
        assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[c] && done_i[c]) |=> !grant_o[c]);
        // R4: a stalled core only leaves the stall by being granted
        assert_stall_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
            stall_o[c] |=> (stall_o[c] || grant_o[c]));
    end

endmodule

// File: tb/region_lock_unit_bench.sv
`timescale 1ns/1ps
module region_lock_unit_bench;

    localparam int NC = 4;
    localparam int AW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     req = '0;
    logic [NC*AW-1:0]  addr = '0;
    logic [NC-1:0]     done = '0;
    logic [NC-1:0]     grant, stall;
    logic              err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    region_lock_unit u_region_lock_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .addr_i  (addr),
        .done_i  (done),
        .grant_o (grant),
        .stall_o (stall),
        .err_o   (err)
    );

    task automatic chk(input string rq, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", rq, act, exp);
        end
    endtask

    task automatic expect_gs(input string rq, input logic [NC-1:0] g, input logic [NC-1:0] s);
        chk({rq, " grant"}, grant, g);
        chk({rq, " stall"}, stall, s);
    endtask

    task automatic set_addr(input int c, input logic [AW-1:0] a);
        addr[c*AW +: AW] = a;
    endtask

    // Drive one cycle of request/done, sample just after the edge
    task automatic go(input logic [NC-1:0] r, input logic [NC-1:0] d);
        req  = r;
        done = d;
        @(posedge clk);
        #1;
        req  = '0;
        done = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req   = '0;
        done  = '0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        expect_gs("R1 reset", 4'b0000, 4'b0000);
        chk("R1 reset err", {3'b000, err}, 4'b0000);

        // Single free request, held, request ignored while holding
        set_addr(0, 16'h1000);
        go(4'b0001, 4'b0000);
        expect_gs("R1 R3 first grant", 4'b0001, 4'b0000);
        go(4'b0000, 4'b0000);
        expect_gs("R3 grant held", 4'b0001, 4'b0000);
        set_addr(0, 16'h2000);
        go(4'b0001, 4'b0000);
        expect_gs("R10 req while holding", 4'b0001, 4'b0000);
        go(4'b0000, 4'b0001);
        expect_gs("R5 release", 4'b0000, 4'b0000);
        chk("R9 no error on valid done", {3'b000, err}, 4'b0000);

        // Line conflict, independent line, full table
        set_addr(0, 16'h1000);
        go(4'b0001, 4'b0000);
        set_addr(1, 16'h103F);
        set_addr(2, 16'h1040);
        go(4'b0110, 4'b0000);
        expect_gs("R2 R4 R7 same line vs next line", 4'b0101, 4'b0010);
        set_addr(3, 16'h2000);
        go(4'b1000, 4'b0000);
        expect_gs("R8 table full", 4'b0101, 4'b1010);
        go(4'b0000, 4'b0100);
        expect_gs("R5 R8 entry freeing", 4'b0001, 4'b1010);
        go(4'b0000, 4'b0000);
        expect_gs("R8 waiter takes freed entry", 4'b1001, 4'b0010);
        go(4'b0000, 4'b0001);
        expect_gs("R5 holder drops", 4'b1000, 4'b0010);
        go(4'b0000, 4'b0000);
        expect_gs("R5 waiter granted next edge", 4'b1010, 4'b0000);
        go(4'b0000, 4'b1010);
        expect_gs("R5 all released", 4'b0000, 4'b0000);

        // Arrival order beats index
        set_addr(0, 16'h3000);
        go(4'b0001, 4'b0000);
        set_addr(3, 16'h3010);
        go(4'b1000, 4'b0000);
        set_addr(1, 16'h3020);
        go(4'b0010, 4'b0000);
        expect_gs("R4 two waiters", 4'b0001, 4'b1010);
        go(4'b0000, 4'b0001);
        go(4'b0000, 4'b0000);
        expect_gs("R6 earlier arrival first", 4'b1000, 4'b0010);
        go(4'b0000, 4'b1000);
        go(4'b0000, 4'b0000);
        expect_gs("R6 second arrival", 4'b0010, 4'b0000);
        go(4'b0000, 4'b0010);

        // Same-cycle tie, later arrival cannot overtake
        set_addr(0, 16'h4000);
        go(4'b0001, 4'b0000);
        set_addr(1, 16'h4000);
        set_addr(2, 16'h4008);
        go(4'b0110, 4'b0000);
        set_addr(3, 16'h4030);
        go(4'b1000, 4'b0000);
        expect_gs("R6 three queued", 4'b0001, 4'b1110);
        go(4'b0000, 4'b0001);
        go(4'b0000, 4'b0000);
        expect_gs("R6 tie lowest index", 4'b0010, 4'b1100);
        go(4'b0000, 4'b0010);
        go(4'b0000, 4'b0000);
        expect_gs("R6 tie second", 4'b0100, 4'b1000);
        go(4'b0000, 4'b0100);
        go(4'b0000, 4'b0000);
        expect_gs("R6 late arrival last", 4'b1000, 4'b0000);
        go(4'b0000, 4'b1000);

        // Stray done pulses
        set_addr(0, 16'h5000);
        go(4'b0001, 4'b0000);
        go(4'b0000, 4'b0100);
        expect_gs("R9 idle done no effect", 4'b0001, 4'b0000);
        chk("R9 err set", {3'b000, err}, 4'b0001);
        set_addr(1, 16'h5000);
        go(4'b0010, 4'b0000);
        go(4'b0000, 4'b0010);
        expect_gs("R9 stalled done no effect", 4'b0001, 4'b0010);
        go(4'b0000, 4'b0000);
        go(4'b0000, 4'b0000);
        chk("R9 err sticky", {3'b000, err}, 4'b0001);
        go(4'b0000, 4'b0001);
        go(4'b0000, 4'b0000);
        expect_gs("R9 stalled core still queued", 4'b0010, 4'b0000);
        go(4'b0000, 4'b0010);
        do_reset();
        chk("R1 reset clears err", {3'b000, err}, 4'b0000);
        expect_gs("R1 reset outputs", 4'b0000, 4'b0000);

        // Sweep every core pair, same line and adjacent lines, same cycle
        for (int i = 0; i < NC; i++) begin
            for (int j = i + 1; j < NC; j++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [NC-1:0] bi, bj;
                    bi = NC'(1) << i;
                    bj = NC'(1) << j;
                    set_addr(i, (s == 1) ? 16'h6000 : 16'h603F);
                    set_addr(j, (s == 1) ? 16'h603F : 16'h6040);
                    go(bi | bj, 4'b0000);
                    if (s == 1) begin
                        expect_gs("R2 R6 sweep tie same line", bi, bj);
                        go(4'b0000, bi);
                        expect_gs("R5 sweep release", 4'b0000, bj);
                        go(4'b0000, 4'b0000);
                        expect_gs("R5 sweep resume", bj, 4'b0000);
                        go(4'b0000, bj);
                    end else begin
                        expect_gs("R2 R7 sweep adjacent lines", bi | bj, 4'b0000);
                        go(4'b0000, bi | bj);
                    end
                    expect_gs("R5 sweep idle", 4'b0000, 4'b0000);
                end
            end
        end
        chk("R9 sweep no error", {3'b000, err}, 4'b0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule